// File: doc/BRIEF.md
# Character-Timing Sync Generator with Selectable Controller Behaviour

This block generates the horizontal and vertical sync pulses of a character-based video timing controller. Three counters advance on every character clock: a character position within the line (wrapping after the horizontal total), a scanline within the character row (wrapping after the maximum scanline), and a row within the frame (wrapping after the vertical total). Sync start positions and the horizontal pulse width come from register inputs. Sync never stalls or reloads any counter.

A 3-bit behaviour-select input chooses one of five controller flavours, numbered 0 to 4. Codes 5 to 7 behave like 3 and 4. The flavours differ in six ways: how a zero horizontal width is read, whether horizontal pulses may follow each other with no gap, the horizontal output delay, what starts a vertical pulse, whether a vertical pulse can run without reaching the pin, and the mid-line vertical start in interlace. A vertical pulse lasts 16 scanlines. Besides the pin, the block exports a flag that shows when a vertical pulse is being timed.

Top module: `crtc_sync_gen`

## Requirements
- R1: The character counter wraps to 0 after `h_total`, so every horizontal pulse repeats with a period of `h_total`+1 clocks. The field bit flips at every frame wrap, which is the clock where all three counters wrap together. Reset clears the field bit to the even field.
- R2: A horizontal pulse starts on the clock after the character counter equals `h_sync_pos`, provided no pulse is running. It stays high for `h_sync_width` clocks. On behaviours 0 and 1 a width of 0 produces no pulse at all.
- R3: On behaviours 2 to 4 a width of 0 produces a pulse 16 clocks long.
- R4: On behaviour 0, when a pulse ends on the same character where the counter equals `h_sync_pos`, the end wins. The output drops and no new pulse starts in that line.
- R5: On behaviours 1 to 4 the same coincidence restarts the pulse at once, so the output stays high with no gap.
- R6: On behaviours 3 and 4 the `hsync` output is exactly one clock later than on behaviour 2 for the same register values.
- R7: On behaviours 0 to 2 a vertical pulse starts whenever the row counter equals `v_sync_pos` and no vertical pulse is running.
- R8: On behaviours 3 and 4 a vertical pulse also needs the scanline counter at 0 and the character counter at 0 on the same clock.
- R9: A vertical pulse ends on the 16th wrap of the character counter after it starts. While it runs, the row condition is ignored. If the row still matches after the pulse ends, a new pulse starts.
- R10: On behaviour 2, a vertical pulse that starts while the horizontal pulse is high holds `vsync_busy` and runs its full length, but `vsync` stays low.
- R11: When `interlace` bit 0 is 1 and the field is even, a vertical pulse may start only when the character counter equals `h_total`/2 (integer halving). This condition replaces the character-0 condition of R8.
- R12: While reset is held, `hsync`, `vsync` and `vsync_busy` are 0.
- R13: Sync activity never disturbs the counters, so horizontal timing continues unchanged during vertical pulses and repeated vertical pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| behaviour | input | 3 | Controller behaviour select (0..4; 5..7 act as 3/4) |
| interlace | input | 2 | Interlace mode; bit 0 set means interlaced |
| h_total | input | 8 | Last character index of a line |
| h_sync_pos | input | 8 | Character index that starts the horizontal pulse |
| h_sync_width | input | 4 | Horizontal pulse width in characters |
| v_total | input | 7 | Last row index of a frame |
| v_sync_pos | input | 7 | Row index that starts the vertical pulse |
| max_scan | input | 5 | Last scanline index within a row |
| hsync | output | 1 | Horizontal sync output |
| vsync | output | 1 | Vertical sync output pin |
| vsync_busy | output | 1 | Vertical pulse is being timed (includes ghost pulses) |

## Verification
The hardest states to reach are the exact clock coincidences. One is a horizontal pulse that ends on the very character that would start the next one. Another is a vertical start that lands while the horizontal pulse is high. The bench reaches the first by setting the width to `h_total`+1, so the end and the start position always meet. It reaches the second by placing the horizontal pulse across character 0, so the row that matches `v_sync_pos` opens with the pulse already high. A third case is the retrigger inside a row that is longer than the pulse, reached by making the row 20 scanlines tall. A behavioural model then follows every clock of these runs and of the interlaced runs, across two fields.

// File: rtl/crtc_sync_pkg.sv
package crtc_sync_pkg;

  typedef logic [2:0] behav_t;

  // Flavours 3 and 4 (and unused codes above) share the late-output group.
  function automatic logic late_group(input behav_t b);
    return (b >= 3'd3);
  endfunction

  function automatic logic zero_width_full(input behav_t b);
    return (b >= 3'd2);
  endfunction

  function automatic logic allows_contiguous(input behav_t b);
    return (b != 3'd0);
  endfunction

  function automatic logic ghost_capable(input behav_t b);
    return (b == 3'd2);
  endfunction

endpackage

// File: rtl/crtc_timing_counters.sv
module crtc_timing_counters #(
  parameter int HW = 8,
  parameter int VW = 7,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_total,
  input  logic [SW-1:0] max_scan,
  input  logic [VW-1:0] v_total,
  output logic [HW-1:0] h_cnt,
  output logic [SW-1:0] l_cnt,
  output logic [VW-1:0] r_cnt,
  output logic          field_odd,
  output logic          line_wrap,
  output logic          frame_wrap
);

  logic row_wrap;

  always_comb begin
    line_wrap  = (h_cnt == h_total);
    row_wrap   = line_wrap && (l_cnt == max_scan);
    frame_wrap = row_wrap && (r_cnt == v_total);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt     <= '0;
      l_cnt     <= '0;
      r_cnt     <= '0;
      field_odd <= 1'b0;
    end else begin
      h_cnt <= line_wrap ? '0 : h_cnt + 1'b1;
      if (line_wrap) l_cnt <= row_wrap ? '0 : l_cnt + 1'b1;
      if (row_wrap)  r_cnt <= frame_wrap ? '0 : r_cnt + 1'b1;
      if (frame_wrap) field_odd <= ~field_odd;
    end
  end

  AST_H_WRAPS_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    line_wrap |=> (h_cnt == '0)); // R1
  AST_FIELD_FLIPS: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> (field_odd != $past(field_odd))); // R1

endmodule

// File: rtl/crtc_hsync_unit.sv
module crtc_hsync_unit
  import crtc_sync_pkg::*;
#(
  parameter int HW = 8,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  behav_t        behaviour,
  input  logic [HW-1:0] h_cnt,
  input  logic [HW-1:0] h_sync_pos,
  input  logic [WW-1:0] h_sync_width,
  output logic          hs_active,
  output logic          hsync
);

  logic [WW-1:0] wcnt;
  logic [WW-1:0] wcnt_inc;
  logic          hs_dly;
  logic          pos_hit;
  logic          may_start;
  logic          end_hit;

  always_comb begin
    wcnt_inc  = wcnt + 1'b1;
    pos_hit   = (h_cnt == h_sync_pos);
    may_start = (h_sync_width != '0) || zero_width_full(behaviour);
    end_hit   = (wcnt_inc == h_sync_width);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_active <= 1'b0;
      wcnt      <= '0;
      hs_dly    <= 1'b0;
    end else begin
      hs_dly <= hs_active;
      if (!hs_active) begin
        if (pos_hit && may_start) begin
          hs_active <= 1'b1;
          wcnt      <= '0;
        end
      end else if (end_hit) begin
        if (pos_hit && allows_contiguous(behaviour)) wcnt <= '0;
        else hs_active <= 1'b0;
      end else begin
        wcnt <= wcnt_inc;
      end
    end
  end

  assign hsync = late_group(behaviour) ? hs_dly : hs_active;

  AST_HS_ZERO_WIDTH_OFF: assert property (@(posedge clk) disable iff (rst)
    (behaviour < 3'd2 && h_sync_width == '0 && !hs_active) |=> !hs_active); // R2
  AST_HS_END_WINS: assert property (@(posedge clk) disable iff (rst)
    (behaviour == 3'd0 && hs_active && end_hit) |=> !hs_active); // R4
  AST_HS_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    (behaviour != 3'd0 && hs_active && end_hit && pos_hit) |=> hs_active); // R5

endmodule

// File: rtl/crtc_vsync_unit.sv
module crtc_vsync_unit
  import crtc_sync_pkg::*;
#(
  parameter int HW     = 8,
  parameter int VW     = 7,
  parameter int SW     = 5,
  parameter int VS_LEN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  behav_t        behaviour,
  input  logic [1:0]    interlace,
  input  logic          field_odd,
  input  logic [HW-1:0] h_cnt,
  input  logic [SW-1:0] l_cnt,
  input  logic [VW-1:0] r_cnt,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_sync_pos,
  input  logic          line_wrap,
  input  logic          hs_active,
  output logic          vsync,
  output logic          vsync_busy
);

  localparam int LW = (VS_LEN > 1) ? $clog2(VS_LEN) : 1;
  localparam logic [LW-1:0] LAST_LINE = LW'(VS_LEN - 1);

  logic [LW-1:0] lines;
  logic          mid_line;
  logic [HW-1:0] start_col;
  logic          start;
  logic          ghost;

  always_comb begin
    mid_line  = interlace[0] && !field_odd;
    start_col = mid_line ? (h_total >> 1) : '0;
    if (late_group(behaviour))
      start = (r_cnt == v_sync_pos) && (l_cnt == '0) && (h_cnt == start_col);
    else
      start = (r_cnt == v_sync_pos) && (!mid_line || h_cnt == start_col);
    ghost = ghost_capable(behaviour) && hs_active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_busy <= 1'b0;
      vsync      <= 1'b0;
      lines      <= '0;
    end else if (!vsync_busy) begin
      if (start) begin
        vsync_busy <= 1'b1;
        vsync      <= !ghost;
        lines      <= '0;
      end
    end else if (line_wrap) begin
      if (lines == LAST_LINE) begin
        vsync_busy <= 1'b0;
        vsync      <= 1'b0;
      end else begin
        lines <= lines + 1'b1;
      end
    end
  end

  AST_VS_PIN_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    vsync |-> vsync_busy); // R10
  AST_VS_HOLDS_BETWEEN_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (vsync_busy && !line_wrap) |=> vsync_busy); // R9
  AST_VS_GHOST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!vsync_busy && start && ghost) |=> (vsync_busy && !vsync)); // R10

endmodule

// File: rtl/crtc_sync_gen.sv
module crtc_sync_gen
  import crtc_sync_pkg::*;
#(
  parameter int HW     = 8,
  parameter int VW     = 7,
  parameter int SW     = 5,
  parameter int WW     = 4,
  parameter int VS_LEN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    behaviour,
  input  logic [1:0]    interlace,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_sync_pos,
  input  logic [WW-1:0] h_sync_width,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_sync_pos,
  input  logic [SW-1:0] max_scan,
  output logic          hsync,
  output logic          vsync,
  output logic          vsync_busy
);

  logic [HW-1:0] h_cnt;
  logic [SW-1:0] l_cnt;
  logic [VW-1:0] r_cnt;
  logic          field_odd;
  logic          line_wrap;
  logic          frame_wrap;
  logic          hs_active;

  crtc_timing_counters #(.HW(HW), .VW(VW), .SW(SW)) u_cnt (
    .clk(clk), .rst(rst), .h_total(h_total), .max_scan(max_scan),
    .v_total(v_total), .h_cnt(h_cnt), .l_cnt(l_cnt), .r_cnt(r_cnt),
    .field_odd(field_odd), .line_wrap(line_wrap), .frame_wrap(frame_wrap)
  );

  crtc_hsync_unit #(.HW(HW), .WW(WW)) u_hs (
    .clk(clk), .rst(rst), .behaviour(behaviour), .h_cnt(h_cnt),
    .h_sync_pos(h_sync_pos), .h_sync_width(h_sync_width),
    .hs_active(hs_active), .hsync(hsync)
  );

  crtc_vsync_unit #(.HW(HW), .VW(VW), .SW(SW), .VS_LEN(VS_LEN)) u_vs (
    .clk(clk), .rst(rst), .behaviour(behaviour), .interlace(interlace),
    .field_odd(field_odd), .h_cnt(h_cnt), .l_cnt(l_cnt), .r_cnt(r_cnt),
    .h_total(h_total), .v_sync_pos(v_sync_pos), .line_wrap(line_wrap),
    .hs_active(hs_active), .vsync(vsync), .vsync_busy(vsync_busy)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!hsync && !vsync && !vsync_busy)); // R12

endmodule

// File: tb/crtc_sync_gen_bench.sv
module crtc_sync_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] c_beh = '0;
  logic [1:0] c_il = '0;
  logic [7:0] c_r0 = 8'd7, c_r2 = 8'd3;
  logic [3:0] c_r3 = 4'd2;
  logic [6:0] c_r4 = 7'd9, c_r7 = 7'd2;
  logic [4:0] c_r9 = 5'd3;
  logic       hsync, vsync, vsync_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_sync_gen u_crtc_sync_gen (
    .clk(clk), .rst(rst), .behaviour(c_beh), .interlace(c_il),
    .h_total(c_r0), .h_sync_pos(c_r2), .h_sync_width(c_r3),
    .v_total(c_r4), .v_sync_pos(c_r7), .max_scan(c_r9),
    .hsync(hsync), .vsync(vsync), .vsync_busy(vsync_busy)
  );

  // Behavioural reference model, stepped on each rising edge.
  int m_h, m_l, m_r, m_fld, m_hs, m_wc, m_hsd, m_vb, m_vl, m_vp;

  always @(posedge clk) begin
    int ohs, beh, half, wnext, go, wrap, fwrap, mid;
    if (rst) begin
      m_h = 0; m_l = 0; m_r = 0; m_fld = 0;
      m_hs = 0; m_wc = 0; m_hsd = 0; m_vb = 0; m_vl = 0; m_vp = 0;
    end else begin
      beh = c_beh; ohs = m_hs; half = c_r0 / 2;
      wrap  = (m_h == c_r0);
      fwrap = wrap && (m_l == c_r9) && (m_r == c_r4);
      mid   = c_il[0] && (m_fld == 0);
      // horizontal
      m_hsd = ohs;
      if (!ohs) begin
        if (m_h == c_r2 && (c_r3 != 0 || beh >= 2)) begin m_hs = 1; m_wc = 0; end
      end else begin
        wnext = (m_wc + 1) % 16;
        if (wnext == c_r3) begin
          if (m_h == c_r2 && beh != 0) m_wc = 0; else m_hs = 0;
        end else m_wc = wnext;
      end
      // vertical
      if (beh >= 3) go = (m_r == c_r7) && (m_l == 0) && (m_h == (mid ? half : 0));
      else          go = (m_r == c_r7) && (!mid || m_h == half);
      if (!m_vb) begin
        if (go) begin m_vb = 1; m_vl = 0; m_vp = !(beh == 2 && ohs); end
      end else if (wrap) begin
        if (m_vl == 15) begin m_vb = 0; m_vp = 0; end else m_vl++;
      end
      // counters
      if (wrap) begin
        m_h = 0;
        if (m_l == c_r9) begin
          m_l = 0;
          m_r = (m_r == c_r4) ? 0 : m_r + 1;
        end else m_l++;
      end else m_h++;
      if (fwrap) m_fld = 1 - m_fld;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Per-scenario statistics.
  int cyc, run_hi, max_hi, run_lo, min_gap, first_rise, busy_run, max_busy;
  bit fell_after_rise, vs_seen, busy_seen, prev_hs, prev_busy;

  task automatic scenario(input int beh, input int il, input int r0, input int r2,
                          input int r3, input int r4, input int r7, input int r9,
                          input int ncyc, input string hs_tag, input string vs_tag);
    @(negedge clk);
    rst = 1; c_beh = 3'(beh); c_il = 2'(il); c_r0 = 8'(r0); c_r2 = 8'(r2);
    c_r3 = 4'(r3); c_r4 = 7'(r4); c_r7 = 7'(r7); c_r9 = 5'(r9);
    @(negedge clk);
    @(negedge clk);
    check(!hsync && !vsync && !vsync_busy, "R12", "outputs in reset",
          {hsync, vsync, vsync_busy}, 0);
    rst = 0;
    cyc = 0; run_hi = 0; max_hi = 0; run_lo = 0; min_gap = 1 << 30;
    first_rise = -1; busy_run = 0; max_busy = 0;
    fell_after_rise = 0; vs_seen = 0; busy_seen = 0; prev_hs = 0; prev_busy = 0;
    repeat (ncyc) begin
      @(negedge clk);
      cyc++;
      check(hsync == ((beh >= 3) ? m_hsd[0] : m_hs[0]), hs_tag, "hsync", hsync,
            (beh >= 3) ? m_hsd : m_hs);
      check(vsync == m_vp[0], vs_tag, "vsync", vsync, m_vp);
      check(vsync_busy == m_vb[0], "R9", "vsync_busy", vsync_busy, m_vb);
      if (hsync) begin
        if (!prev_hs && first_rise < 0) first_rise = cyc;
        if (!prev_hs && first_rise >= 0 && run_lo > 0 && cyc != first_rise && run_lo < min_gap)
          min_gap = run_lo;
        run_hi++; run_lo = 0;
        if (run_hi > max_hi) max_hi = run_hi;
      end else begin
        if (prev_hs) fell_after_rise = 1;
        run_hi = 0; run_lo++;
      end
      if (vsync) vs_seen = 1;
      if (vsync_busy) begin
        busy_seen = 1; busy_run++;
      end else begin
        if (prev_busy && busy_run > max_busy) max_busy = busy_run;
        busy_run = 0;
      end
      prev_hs = hsync; prev_busy = vsync_busy;
    end
  endtask

  int rise_b2, rise_b3;

  initial begin
    // Basic run, behaviour 0: width 2, vsync lasts 16 wraps (16*8-1 busy clocks).
    scenario(0, 0, 7, 3, 2, 9, 2, 3, 700, "R1", "R7");
    check(max_hi == 2, "R2", "hsync high run", max_hi, 2);
    check(max_busy == 127, "R9", "busy run length", max_busy, 127);
    // Zero width on behaviour 1: no pulse.
    scenario(1, 0, 7, 3, 0, 9, 2, 3, 400, "R2", "R7");
    check(max_hi == 0, "R2", "hsync high run width0", max_hi, 0);
    // Zero width on behaviour 2, long line: 16-character pulse.
    scenario(2, 0, 31, 3, 0, 3, 1, 3, 700, "R3", "R7");
    check(max_hi == 16, "R3", "hsync high run width0", max_hi, 16);
    // End/start coincidence, behaviour 0: gap of at least one character.
    scenario(0, 0, 7, 3, 8, 9, 2, 3, 400, "R4", "R7");
    check(first_rise > 0 && min_gap >= 1 && fell_after_rise, "R4", "gap seen", min_gap, 1);
    // Same coincidence, behaviour 1: output stays high.
    scenario(1, 0, 7, 3, 8, 9, 2, 3, 400, "R5", "R7");
    check(first_rise > 0 && !fell_after_rise, "R5", "hsync never falls", fell_after_rise, 0);
    // Output delay: behaviour 2 versus 3, same registers.
    scenario(2, 0, 7, 3, 2, 9, 2, 3, 200, "R6", "R7");
    rise_b2 = first_rise;
    scenario(3, 0, 7, 3, 2, 9, 2, 3, 700, "R6", "R8");
    rise_b3 = first_rise;
    check(rise_b3 - rise_b2 == 1, "R6", "late hsync offset", rise_b3 - rise_b2, 1);
    // Behaviour 4 trigger with pulse across column 0.
    scenario(4, 0, 7, 6, 4, 9, 2, 3, 700, "R6", "R8");
    check(vs_seen, "R8", "vsync seen on behaviour 4", vs_seen, 1);
    // Ghost vsync: hsync high when the row opens.
    scenario(2, 0, 7, 6, 4, 9, 2, 3, 700, "R3", "R10");
    check(!vs_seen && busy_seen, "R10", "ghost busy without pin", vs_seen, 0);
    // Same placement on behaviour 1: pin asserts.
    scenario(1, 0, 7, 6, 4, 9, 2, 3, 700, "R5", "R7");
    check(vs_seen, "R7", "vsync seen on behaviour 1", vs_seen, 1);
    // Interlace, two frames, both trigger groups.
    scenario(0, 1, 7, 3, 2, 4, 1, 3, 900, "R1", "R11");
    check(vs_seen, "R11", "interlace vsync seen", vs_seen, 1);
    scenario(3, 3, 9, 3, 2, 4, 1, 3, 1100, "R6", "R11");
    check(vs_seen, "R11", "interlace late vsync seen", vs_seen, 1);
    // Tall row: retrigger inside one row, counters undisturbed.
    scenario(0, 0, 7, 3, 2, 3, 1, 19, 1400, "R13", "R9");
    check(max_busy == 127, "R9", "retrigger busy run", max_busy, 127);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule